// File: doc/BRIEF.md
# Multi-Format Serial Master

This block is a serial bus master that exchanges one data word per request with an external slave. A single bit engine drives a serial clock, a data output and one select pin per attached slave, and samples a data input. A two-bit format field picks the wire protocol for each transfer. The options are four-wire full-duplex SPI, SSP-style framed full-duplex transfer, and Microwire-style half-duplex transfer, which opens with a control word.

The host side is a plain parallel port. The host presents the format, word length, clock divider, target slave and transmit word, then raises `tx_valid` while the block is idle. The block captures all of these at that edge. It runs the transfer, holds `busy` high throughout, and returns the received word with a one-cycle `rx_valid` strobe. In SSP format, the pin that acts as a slave select in the other formats carries a one-period frame pulse instead.

Top module: `serial_master`

## Requirements
- R1: `cfg_fmt` encodes 00 = SPI, 01 = SSP and 10 = Microwire, and 11 behaves exactly like SPI. Format, length, divider, target and transmit data are captured when a transfer starts, and later changes to those inputs do not alter that transfer.
- R2: In SPI and Microwire formats, every `ss` pin is high while idle. During a transfer, the pin indexed by `cfg_target` is low for the whole transfer and the other pins stay high.
- R3: In SSP format, every `ss` pin is low while idle. The target pin is high for exactly the first serial clock period of the transfer (during which `mosi` is 0) and is low during all data bits.
- R4: `sclk` idles low. Each bit period starts with `sclk` low and ends with `sclk` high, the slave samples `miso` on the rising edge, and `mosi` changes only while `sclk` is low. The first rising edge comes one half-period after the select pin changes.
- R5: In SPI and SSP formats, the low `L` bits of `tx_data` go out MSB first, and the `L` bits sampled in the same periods form `rx_data` right-aligned, with the upper bits zero.
- R6: In Microwire format, `tx_ctrl` (8 bits) is sent MSB first. One turnaround period follows, then `L` data periods. `mosi` is 0 from the turnaround onward, and `rx_data` holds only the bits sampled in the data periods.
- R7: The word length `L` is `cfg_len` clamped to the range 4 to 16.
- R8: The serial clock period is `P` system cycles, where `P` = `cfg_div` rounded down to even, with a minimum of 2. Each half lasts `P/2` cycles, and `busy` is high for exactly `P` times the number of bit periods (L, L+1 or L+9).
- R9: `busy` rises on the cycle after an accepted request and falls when the select pin is released. `rx_valid` is a single-cycle pulse in the first cycle with `busy` low.
- R10: A `tx_valid` seen while `busy` is high is dropped. If `tx_valid` is held high across the end of a transfer, the next transfer starts after exactly one idle cycle.
- R11: At most one slave pin differs from its idle level at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Wire format select |
| cfg_len | input | 5 | Requested word length in bits |
| cfg_div | input | 8 | System cycles per serial clock period |
| cfg_target | input | 2 | Index of the slave to address |
| tx_valid | input | 1 | Start request, accepted when idle |
| tx_data | input | 16 | Word to send (low L bits used) |
| tx_ctrl | input | 8 | Microwire control word |
| busy | output | 1 | Transfer in progress |
| rx_valid | output | 1 | One-cycle strobe that rx_data is new |
| rx_data | output | 16 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| ss | output | 4 | Per-slave select / frame pins |

## Verification
The completion of one transfer and the acceptance of the next can fall on adjacent edges. Input changes mid-transfer can coincide with bit shifting. The bench holds `tx_valid` high across the end of a transfer and expects `rx_valid` in the single idle cycle, followed by `busy` on the very next cycle. In random runs it also pulses `tx_valid` and scrambles every configuration input while a transfer is in flight. The bench then judges the serial bit stream, the select pins, the received word and the busy length against values computed from the settings captured at the start. Directed cases cover the reserved format code, length clamping at both ends, and divider values 0, 1 and odd.

// File: rtl/sm_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial master: wire-format encoding and its
// normalisation. Assumes the 2-bit field layout is fixed by the host.
package sm_pkg;

    typedef enum logic [1:0] {
        FMT_SPI = 2'b00,
        FMT_SSP = 2'b01,
        FMT_MW  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    // Map the reserved code onto SPI so the engine sees three formats only.
    function automatic fmt_e norm_fmt(input logic [1:0] code);
        return (code == 2'b11) ? FMT_SPI : fmt_e'(code);
    endfunction

endpackage

// File: rtl/sm_halfclk.sv
`timescale 1ns/1ps
// Half-period timer: while run is high, emits a one-cycle tick every
// `half` system cycles. Assumes half >= 1; restarts from zero when run drops.
module sm_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half - DIV_W'(1));

    // Count system cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sm_shifter.sv
`timescale 1ns/1ps
// Bit datapath: loads a format-specific transmit image at start, shifts it
// out MSB first, and collects sampled bits into a right-aligned word.
// Assumes len is already clamped to MIN..MAX by the caller.
module sm_shifter
    import sm_pkg::*;
#(
    parameter int MAX_LEN  = 16,
    parameter int CTRL_LEN = 8,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  fmt_e                fmt,
    input  logic [LEN_W-1:0]    len,
    input  logic [MAX_LEN-1:0]  tx_data,
    input  logic [CTRL_LEN-1:0] tx_ctrl,
    input  logic                shift_en,
    input  logic                sample_en,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_LEN-1:0]  rx_word
);

    localparam int TXW = CTRL_LEN + 1 + MAX_LEN;

    logic [TXW-1:0]     tx_q;
    logic [MAX_LEN-1:0] rx_q;
    logic [MAX_LEN-1:0] aligned;

    assign aligned = tx_data << (MAX_LEN - int'(len));
    assign mosi    = tx_q[TXW-1];
    assign rx_word = rx_q;

    // Transmit image: load per format, then shift left once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            case (fmt)
                FMT_SSP: tx_q <= {1'b0, aligned, {(TXW-MAX_LEN-1){1'b0}}};
                FMT_MW:  tx_q <= {tx_ctrl, 1'b0, {MAX_LEN{1'b0}}};
                default: tx_q <= {aligned, {(TXW-MAX_LEN){1'b0}}};
            endcase
        end else if (shift_en) begin
            tx_q <= {tx_q[TXW-2:0], 1'b0};
        end
    end

    // Receive word: cleared at start, one bit appended per data-phase edge.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_q <= '0;
        end else if (sample_en) begin
            rx_q <= {rx_q[MAX_LEN-2:0], miso};
        end
    end

endmodule

// File: rtl/sm_select.sv
`timescale 1ns/1ps
// Select-pin decoder: drives each slave pin to the idle level of the active
// format, or to the asserted level when it is the busy target. In SSP the
// asserted level is the frame flag. Assumes fmt is already normalised.
module sm_select
    import sm_pkg::*;
#(
    parameter int NUM_SS = 4,
    parameter int SS_W   = 2
) (
    input  logic              busy,
    input  fmt_e              fmt,
    input  logic              frame,
    input  logic [SS_W-1:0]   target,
    output logic [NUM_SS-1:0] ss
);

    logic idle_lvl;
    logic act_lvl;

    assign idle_lvl = (fmt != FMT_SSP);
    assign act_lvl  = (fmt == FMT_SSP) ? frame : 1'b0;

    for (genvar i = 0; i < NUM_SS; i++) begin : g_pin
        // Pin i: asserted level only while busy on this index.
        assign ss[i] = (busy && target == SS_W'(i)) ? act_lvl : idle_lvl;
    end

endmodule

// File: rtl/serial_master.sv
`timescale 1ns/1ps
// Multi-format serial master top. Captures configuration on an accepted
// request, sequences bit periods (frame slot, control word, turnaround and
// data as the format needs) and returns the sampled word. Assumes the host
// holds tx_valid until busy rises if it wants the request honoured.
module serial_master
    import sm_pkg::*;
#(
    parameter int NUM_SS   = 4,
    parameter int MAX_LEN  = 16,
    parameter int MIN_LEN  = 4,
    parameter int CTRL_LEN = 8,
    parameter int DIV_W    = 8,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int SS_W    = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_fmt,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [SS_W-1:0]     cfg_target,
    input  logic                tx_valid,
    input  logic [MAX_LEN-1:0]  tx_data,
    input  logic [CTRL_LEN-1:0] tx_ctrl,
    output logic                busy,
    output logic                rx_valid,
    output logic [MAX_LEN-1:0]  rx_data,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_SS-1:0]   ss
);

    localparam int TXW    = CTRL_LEN + 1 + MAX_LEN;
    localparam int SLOT_W = $clog2(TXW + 1);

    fmt_e               fmt_in, fmt_q;
    logic [LEN_W-1:0]   len_in, len_q;
    logic [DIV_W-1:0]   half_in, half_q;
    logic [SS_W-1:0]    tgt_q;
    logic [SLOT_W-1:0]  slots_in, first_in, total_q, first_q, slot_q;
    logic               busy_q, sclk_q, rx_valid_q;
    logic [MAX_LEN-1:0] rx_data_q, rx_word;
    logic               start, tick, rise_ev, fall_ev, last, done;

    // Normalise the live configuration into what a transfer would capture.
    always_comb begin
        fmt_in = norm_fmt(cfg_fmt);
        if (cfg_len < LEN_W'(MIN_LEN))      len_in = LEN_W'(MIN_LEN);
        else if (cfg_len > LEN_W'(MAX_LEN)) len_in = LEN_W'(MAX_LEN);
        else                                len_in = cfg_len;
        half_in = (cfg_div < DIV_W'(2)) ? DIV_W'(1) : (cfg_div >> 1);
        case (fmt_in)
            FMT_SSP: slots_in = SLOT_W'(int'(len_in) + 1);
            FMT_MW:  slots_in = SLOT_W'(int'(len_in) + CTRL_LEN + 1);
            default: slots_in = SLOT_W'(len_in);
        endcase
        first_in = slots_in - SLOT_W'(len_in);
    end

    assign start   = tx_valid && !busy_q;
    assign rise_ev = busy_q && tick && !sclk_q;
    assign fall_ev = busy_q && tick && sclk_q;
    assign last    = (slot_q == total_q - SLOT_W'(1));
    assign done    = fall_ev && last;

    // Transfer sequencer: capture config, walk bit periods, end on last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            slot_q  <= '0;
            total_q <= '0;
            first_q <= '0;
            fmt_q   <= FMT_SPI;
            len_q   <= LEN_W'(MIN_LEN);
            half_q  <= DIV_W'(1);
            tgt_q   <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            sclk_q  <= 1'b0;
            slot_q  <= '0;
            total_q <= slots_in;
            first_q <= first_in;
            fmt_q   <= fmt_in;
            len_q   <= len_in;
            half_q  <= half_in;
            tgt_q   <= cfg_target;
        end else if (rise_ev) begin
            sclk_q <= 1'b1;
        end else if (fall_ev) begin
            sclk_q <= 1'b0;
            if (last) busy_q <= 1'b0;
            else      slot_q <= slot_q + SLOT_W'(1);
        end
    end

    // Result register: publish the collected word with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= done;
            if (done) rx_data_q <= rx_word;
        end
    end

    sm_halfclk #(.DIV_W(DIV_W)) i_halfclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .half  (half_q),
        .tick  (tick)
    );

    sm_shifter #(.MAX_LEN(MAX_LEN), .CTRL_LEN(CTRL_LEN), .LEN_W(LEN_W)) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .fmt       (fmt_in),
        .len       (len_in),
        .tx_data   (tx_data),
        .tx_ctrl   (tx_ctrl),
        .shift_en  (fall_ev && !last),
        .sample_en (rise_ev && (slot_q >= first_q)),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    sm_select #(.NUM_SS(NUM_SS), .SS_W(SS_W)) i_select (
        .busy   (busy_q),
        .fmt    (busy_q ? fmt_q : fmt_in),
        .frame  ((fmt_q == FMT_SSP) && (slot_q == '0)),
        .target (tgt_q),
        .ss     (ss)
    );

    assign busy     = busy_q;
    assign sclk     = sclk_q;
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;

endmodule

// File: rtl/sm_checker.sv
`timescale 1ns/1ps
// Protocol checker for serial_master, attached by bind. Observes ports only.
module sm_checker #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_fmt,
    input logic              tx_valid,
    input logic              busy,
    input logic              rx_valid,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_SS-1:0] ss
);

    // R9
    rx_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!busy && $past(busy)));

    // R9
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2
    spi_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_fmt != 2'b01) |-> (&ss));

    // R3
    ssp_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_fmt == 2'b01) |-> (ss == '0));

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R4
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk) |-> $stable(mosi));

    // R11
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(ss) <= 1 || $countones(~ss) <= 1));

    // R10
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_valid));

endmodule

bind serial_master sm_checker #(.NUM_SS(NUM_SS)) i_sm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_fmt  (cfg_fmt),
    .tx_valid (tx_valid),
    .busy     (busy),
    .rx_valid (rx_valid),
    .sclk     (sclk),
    .mosi     (mosi),
    .ss       (ss)
);

// File: tb/test_serial_master.sv
`timescale 1ns/1ps
module test_serial_master;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_fmt;
    logic [4:0]  cfg_len;
    logic [7:0]  cfg_div;
    logic [1:0]  cfg_target;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic [7:0]  tx_ctrl;
    logic        busy, rx_valid, sclk, mosi, miso;
    logic [15:0] rx_data;
    logic [3:0]  ss;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    serial_master i_serial_master (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_len(cfg_len),
        .cfg_div(cfg_div), .cfg_target(cfg_target), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ctrl(tx_ctrl), .busy(busy), .rx_valid(rx_valid),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .ss(ss)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int eff_len(input int l);
        return (l < 4) ? 4 : ((l > 16) ? 16 : l);
    endfunction

    function automatic int period_of(input int d);
        return (d < 2) ? 2 : (d / 2) * 2;
    endfunction

    function automatic int slots_of(input int f, input int l);
        return (f == 1) ? l + 1 : ((f == 2) ? l + 9 : l);
    endfunction

    function automatic bit exp_mosi(input int f, input int l, input int k,
                                    input logic [15:0] d, input logic [7:0] c);
        if (f == 2) return (k < 8) ? c[7-k] : 1'b0;
        if (f == 1) return (k == 0) ? 1'b0 : d[l-k];
        return d[l-1-k];
    endfunction

    function automatic logic [3:0] exp_ss(input int f, input int k, input int tgt);
        logic [3:0] v;
        for (int i = 0; i < 4; i++) begin
            if (f == 1) v[i] = (i == tgt) && (k == 0);
            else        v[i] = (i != tgt);
        end
        return v;
    endfunction

    function automatic bit miso_of(input int k, input int first, input int l,
                                   input logic [15:0] sw);
        int j = k - first;
        if (j >= 0 && j < l) return sw[l-1-j];
        return 1'b1;
    endfunction

    // One transfer with full monitoring; f is the raw code driven on cfg_fmt.
    task automatic xfer(input int f, input int lcfg, input int dv, input int tgt,
                        input logic [15:0] d, input logic [7:0] c,
                        input logic [15:0] sw, input bit disturb);
        int ef    = (f == 3) ? 0 : f;
        int l     = eff_len(lcfg);
        int p     = period_of(dv);
        int slots = slots_of(ef, l);
        int first = slots - l;
        int ncyc = 0, rises = 0, frise = -1;
        bit prev = 1'b0;
        logic [15:0] mask = 16'((32'd1 << l) - 1);
        @(negedge clk);
        cfg_fmt = 2'(f); cfg_len = 5'(lcfg); cfg_div = 8'(dv);
        cfg_target = 2'(tgt); tx_data = d; tx_ctrl = c; tx_valid = 1'b1;
        miso = miso_of(0, first, l, sw);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after request", 32'(busy), 1);
        while (busy && ncyc < 2000) begin
            ncyc++;
            if (sclk && !prev) begin
                // R4 R5 R6: bit on mosi at each rising edge
                chk(mosi == exp_mosi(ef, l, rises, d, c), "R5 R6 mosi bit",
                    32'(mosi), 32'(exp_mosi(ef, l, rises, d, c)));
                // R2 R3 R11: select pins per bit period
                chk(ss == exp_ss(ef, rises, tgt), "R2 R3 R11 select pins",
                    32'(ss), 32'(exp_ss(ef, rises, tgt)));
                rises++;
                if (rises == 1) frise = ncyc;
                miso = miso_of(rises, first, l, sw);
                if (rises == slots) begin
                    cfg_fmt = 2'(f); cfg_len = 5'(lcfg); cfg_div = 8'(dv);
                    cfg_target = 2'(tgt);
                end
            end
            prev = sclk;
            if (disturb && ncyc == 2) begin
                tx_valid = 1'b1; tx_data = ~d; tx_ctrl = ~c;
                cfg_fmt = 2'($urandom_range(3)); cfg_len = 5'($urandom_range(31));
                cfg_div = 8'($urandom_range(255)); cfg_target = 2'($urandom_range(3));
            end
            if (ncyc == 3) tx_valid = 1'b0;
            @(negedge clk);
        end
        chk(ncyc == p * slots, "R8 busy length", 32'(ncyc), 32'(p * slots));
        chk(frise == p / 2 + 1, "R4 first rise delay", 32'(frise), 32'(p / 2 + 1));
        chk(rises == slots, "R6 R7 bit period count", 32'(rises), 32'(slots));
        chk(rx_valid == 1'b1, "R9 rx_valid strobe", 32'(rx_valid), 1);
        chk(rx_data == (sw & mask), "R5 R6 received word", 32'(rx_data), 32'(sw & mask));
        chk(sclk == 1'b0, "R4 sclk idle", 32'(sclk), 0);
        chk(ss == ((ef == 1) ? 4'h0 : 4'hF), "R2 R3 idle pins", 32'(ss),
            32'((ef == 1) ? 4'h0 : 4'hF));
        if (disturb) begin
            @(negedge clk); @(negedge clk);
            chk(busy == 1'b0, "R10 request during busy dropped", 32'(busy), 0);
        end
    endtask

    initial begin
        int seed = 32'd2024;
        void'($urandom(seed));
        rst_n = 1'b0; cfg_fmt = 2'b00; cfg_len = 5'd8; cfg_div = 8'd4;
        cfg_target = 2'd0; tx_valid = 1'b0; tx_data = '0; tx_ctrl = '0; miso = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && rx_valid == 1'b0, "R9 reset idle", 32'({busy, rx_valid}), 0);
        chk(sclk == 1'b0 && mosi == 1'b0, "R4 reset lines", 32'({sclk, mosi}), 0);
        chk(ss == 4'hF, "R2 reset pins high", 32'(ss), 32'hF);
        chk(rx_data == 16'h0, "R5 reset word", 32'(rx_data), 0);
        cfg_fmt = 2'b01;
        @(negedge clk);
        chk(ss == 4'h0, "R3 SSP idle low", 32'(ss), 0);

        // Directed corners
        xfer(0, 8, 4, 1, 16'h00A5, 8'h00, 16'h005A, 1'b0);   // R5 SPI
        xfer(1, 8, 2, 2, 16'h00C3, 8'h00, 16'h0096, 1'b0);   // R3 SSP
        xfer(2, 12, 4, 3, 16'h0FFF, 8'hB4, 16'h0A5C, 1'b0);  // R6 Microwire
        xfer(3, 6, 2, 0, 16'h002D, 8'h00, 16'h0033, 1'b0);   // R1 reserved code
        xfer(0, 3, 0, 1, 16'h000F, 8'h00, 16'h0009, 1'b0);   // R7 low clamp, R8 div 0
        xfer(1, 20, 1, 2, 16'hBEEF, 8'h00, 16'hF00D, 1'b0);  // R7 high clamp, R8 div 1
        xfer(2, 4, 7, 0, 16'h0000, 8'h81, 16'h000B, 1'b1);   // R8 odd div, R10 R1

        // R10: request held across the end of a transfer
        @(negedge clk);
        cfg_fmt = 2'b00; cfg_len = 5'd4; cfg_div = 8'd2; cfg_target = 2'd1;
        tx_data = 16'h5; miso = 1'b0; tx_valid = 1'b1;
        @(negedge clk);
        while (busy) @(negedge clk);
        chk(rx_valid == 1'b1, "R9 strobe in idle gap", 32'(rx_valid), 1);
        chk(rx_data == 16'h0, "R5 zero word", 32'(rx_data), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R10 back-to-back restart", 32'(busy), 1);
        tx_valid = 1'b0;
        while (busy) @(negedge clk);

        // Constrained random mix
        for (int n = 0; n < 40; n++) begin
            xfer($urandom_range(3), $urandom_range(18, 2), $urandom_range(9),
                 $urandom_range(3), 16'($urandom), 8'($urandom), 16'($urandom),
                 1'($urandom_range(1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule